// File: doc/BRIEF.md
# Wrapping Bit-Field Extract Unit

This datapath unit pulls an unsigned bit field out of a 64-bit operand and returns it right-justified with zeros above it. Two 6-bit position operands choose the field: a first position and a last position. Both positions belong to the field. When the first position is numerically greater than the last position, the field runs from the first position up to bit 63 and then continues from bit 0 up to the last position.

The unit works in two steps. It first rotates the operand right by the first position, which places the field's lowest bit at bit 0. It then clears every bit at or above the field length. The field length is one more than the difference of the two positions, taken modulo 64. Because the unit rotates instead of shifting, it has no shift-by-64 case, and every one of the 4096 position pairs gives a defined result.

The request is qualified by a valid bit. The result sits in one output register with its own valid flag and has one cycle of latency. The register keeps its contents while no request is presented.

Top module: `bfx_extract_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the unit clears `out_valid` to 0 and `out_field` to 0 at that edge.
- R2: `out_valid` after a rising edge equals `in_valid` sampled at that edge, so the latency is exactly one cycle.
- R3: At an edge where `in_valid` is 0, `out_field` keeps its previous value, whatever is on the data inputs.
- R4: When `in_first` <= `in_last`, bits `in_first`..`in_last` of the operand appear at `out_field` bits 0..(`in_last`-`in_first`).
- R5: When `in_first` > `in_last`, operand bits `in_first`..63 appear at result bits 0..(63-`in_first`), and operand bits 0..`in_last` follow them starting at result bit 64-`in_first`.
- R6: The field length is ((`in_last` - `in_first`) mod 64) + 1, and every result bit at or above that length is 0.
- R7: When (`in_last` - `in_first`) mod 64 = 63, the result is the operand rotated right by `in_first`. With `in_first` = 0 this is the operand itself.
- R8: When `in_first` = `in_last`, the result is the single operand bit at that position, placed in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request qualifier; the output register loads only when this is high |
| in_operand | input | 64 | Source operand |
| in_first | input | 6 | Position of the field's lowest bit (bit 0 of the result) |
| in_last | input | 6 | Position of the field's highest bit (inclusive) |
| out_valid | output | 1 | High for one cycle after each accepted request |
| out_field | output | 64 | Right-justified, zero-extended field |

## Verification
The assertions assume that `rst` is held for at least one rising edge before the first request. They also assume that the inputs are at known levels whenever `in_valid` is high. The popcount and length properties are checked only in cycles that carry a request. The bench keeps these conditions by driving every input on the falling edge. It holds reset for several edges before its first request and never leaves an input undriven. It drives the operand with values from `$urandom` or with fixed patterns, so the operand is never X.

// File: rtl/bfx_pkg.sv
package bfx_pkg;

    localparam int unsigned BFX_W     = 64;
    localparam int unsigned BFX_POS_W = $clog2(BFX_W);

    typedef logic [BFX_W-1:0]     bfx_word_t;
    typedef logic [BFX_POS_W-1:0] bfx_pos_t;

    typedef struct packed {
        bfx_word_t operand;
        bfx_pos_t  first;
        bfx_pos_t  last;
    } bfx_req_t;

    typedef struct packed {
        logic      valid;
        bfx_word_t field;
    } bfx_rsp_t;

    // Span between positions, modulo the word size (length minus one).
    function automatic bfx_pos_t bfx_span(input bfx_pos_t first, input bfx_pos_t last);
        return bfx_pos_t'(last - first);
    endfunction

endpackage

// File: rtl/bfx_rotator.sv
module bfx_rotator
    import bfx_pkg::*;
#(
    parameter int unsigned W     = BFX_W,
    parameter int unsigned AMT_W = $clog2(W)
) (
    input  logic [W-1:0]     din_i,
    input  logic [AMT_W-1:0] amt_i,
    output logic [W-1:0]     dout_o
);
    // Logarithmic rotator: stage s rotates right by 2**s when amt bit s is set.
    logic [W-1:0] stage [0:AMT_W];

    assign stage[0] = din_i;

    for (genvar s = 0; s < AMT_W; s++) begin : g_stage
        localparam int unsigned STEP = 1 << s;
        logic [W-1:0] rotated;
        assign rotated      = {stage[s][STEP-1:0], stage[s][W-1:STEP]};
        assign stage[s+1]   = amt_i[s] ? rotated : stage[s];
    end

    assign dout_o = stage[AMT_W];

endmodule

// File: rtl/bfx_mask_gen.sv
module bfx_mask_gen
    import bfx_pkg::*;
#(
    parameter int unsigned W     = BFX_W,
    parameter int unsigned POS_W = $clog2(W)
) (
    input  logic [POS_W-1:0] span_i,
    output logic [W-1:0]     mask_o
);
    // Thermometer mask: bit i set when i does not exceed the span.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign mask_o[i] = (POS_W'(i) <= span_i);
    end

endmodule

// File: rtl/bfx_extract_unit.sv
module bfx_extract_unit
    import bfx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [BFX_W-1:0]     in_operand,
    input  logic [BFX_POS_W-1:0] in_first,
    input  logic [BFX_POS_W-1:0] in_last,
    output logic                 out_valid,
    output logic [BFX_W-1:0]     out_field
);
    localparam int unsigned W     = BFX_W;
    localparam int unsigned POS_W = BFX_POS_W;

    bfx_req_t  req;
    bfx_rsp_t  rsp_q;
    bfx_word_t rotated;
    bfx_word_t mask;
    bfx_pos_t  span;

    assign req.operand = in_operand;
    assign req.first   = in_first;
    assign req.last    = in_last;

    assign span = bfx_span(req.first, req.last);

    bfx_rotator #(.W(W), .AMT_W(POS_W)) u_rot (
        .din_i  (req.operand),
        .amt_i  (req.first),
        .dout_o (rotated)
    );

    bfx_mask_gen #(.W(W), .POS_W(POS_W)) u_mask (
        .span_i (span),
        .mask_o (mask)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q.valid <= in_valid;
            if (in_valid) begin
                rsp_q.field <= rotated & mask;
            end
        end
    end

    assign out_valid = rsp_q.valid;
    assign out_field = rsp_q.field;

    // ------------------------------------------------------------------
    // Assertions
    // ------------------------------------------------------------------
    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!out_valid && out_field == '0)); // R1

    AST_VALID_SET: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R2

    AST_VALID_CLR: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R2

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(out_field)); // R3

    AST_ROT_KEEPS_ONES: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ($countones(rotated) == $countones(in_operand))); // R7

    AST_ROT_ZERO_IDENT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_first == '0) |-> (rotated == in_operand)); // R7

    AST_MASK_LEN: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ($countones(mask) == int'(span) + 1)); // R6

    AST_ZERO_ABOVE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ((out_field >> (int'($past(span)) + 1)) == '0)); // R6

endmodule

// File: tb/bfx_extract_unit_test.sv
module bfx_extract_unit_test;
    import bfx_pkg::*;

    localparam realtime HALF = 2ns;   // 250 MHz
    localparam int      WATCHDOG_CYCLES = 150000;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic [BFX_W-1:0]     in_operand = '0;
    logic [BFX_POS_W-1:0] in_first = '0;
    logic [BFX_POS_W-1:0] in_last = '0;
    logic                 out_valid;
    logic [BFX_W-1:0]     out_field;

    int total = 0;
    int fails = 0;

    always #HALF clk = ~clk;

    bfx_extract_unit uut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_operand (in_operand),
        .in_first   (in_first),
        .in_last    (in_last),
        .out_valid  (out_valid),
        .out_field  (out_field)
    );

    // Reference: walk upward from first (mod 64) for the field length.
    function automatic logic [63:0] ref_extract(input logic [63:0] op, input int f, input int l);
        logic [63:0] r = '0;
        int len = ((l - f + 64) % 64) + 1;
        for (int k = 0; k < len; k++) r[k] = op[(f + k) % 64];
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one request on a falling edge; result is checked on the next falling edge.
    task automatic run_one(input logic [63:0] op, input int f, input int l);
        string tag;
        int len;
        @(negedge clk);
        in_valid   = 1'b1;
        in_operand = op;
        in_first   = BFX_POS_W'(f);
        in_last    = BFX_POS_W'(l);
        @(negedge clk);
        in_valid = 1'b0;
        len = ((l - f + 64) % 64) + 1;
        if (len == 64)      tag = "R7";
        else if (f == l)    tag = "R8";
        else if (f <= l)    tag = "R4";
        else                tag = "R5";
        check(tag, out_field, ref_extract(op, f, l));
        check("R6", (len == 64) ? 64'd0 : (out_field >> len), 64'd0);
        check("R2", 64'(out_valid), 64'd1);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", 64'(out_valid), 64'd0);
        check("R1", out_field, 64'd0);
        rst = 1'b0;
    endtask

    task automatic t_all_pairs();
        for (int f = 0; f < 64; f++) begin
            for (int l = 0; l < 64; l++) begin
                run_one({$urandom, $urandom}, f, l);
            end
        end
    endtask

    task automatic t_patterns();
        for (int f = 0; f < 64; f += 7) begin
            for (int l = 0; l < 64; l += 5) begin
                run_one('1, f, l);
            end
        end
        for (int b = 0; b < 64; b++) begin
            run_one(64'd1 << b, b, b);              // R8 single bit at its own position
            run_one(64'd1 << b, (b + 1) % 64, b);  // R7 full span, bit lands on top
        end
        run_one(64'h0123_4567_89AB_CDEF, 0, 63);   // R7 identity
        check("R7", out_field, 64'h0123_4567_89AB_CDEF);
        run_one(64'hF000_0000_0000_000F, 60, 3);   // R5 wrap
        check("R5", out_field, 64'h0000_0000_0000_00FF);
    endtask

    task automatic t_hold();
        logic [63:0] kept;
        run_one(64'hDEAD_BEEF_CAFE_F00D, 4, 19);
        kept = out_field;
        for (int i = 0; i < 4; i++) begin
            in_operand = {$urandom, $urandom};
            in_first   = BFX_POS_W'(i);
            in_last    = BFX_POS_W'(60 - i);
            @(negedge clk);
            check("R3", out_field, kept);
            check("R2", 64'(out_valid), 64'd0);
        end
    endtask

    task automatic t_back_to_back();
        logic [63:0] a = 64'h1111_2222_3333_4444;
        logic [63:0] b = 64'h8000_0000_0000_0001;
        @(negedge clk);
        in_valid = 1'b1; in_operand = a; in_first = 6'd8; in_last = 6'd23;
        @(negedge clk);
        check("R4", out_field, ref_extract(a, 8, 23));
        in_operand = b; in_first = 6'd63; in_last = 6'd0;
        @(negedge clk);
        in_valid = 1'b0;
        check("R5", out_field, 64'd3);
        check("R2", 64'(out_valid), 64'd1);
        @(negedge clk);
        check("R2", 64'(out_valid), 64'd0);
    endtask

    task automatic t_reset_midrun();
        run_one(64'hFFFF_FFFF_FFFF_FFFF, 0, 31);
        rst = 1'b1;
        @(negedge clk);
        check("R1", 64'(out_valid), 64'd0);
        check("R1", out_field, 64'd0);
        rst = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        t_reset();
        t_all_pairs();
        t_patterns();
        t_hold();
        t_back_to_back();
        t_reset_midrun();
        summary();
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

endmodule